// File: doc/BRIEF.md
# Serial VID Command Receiver

This block receives voltage-identification commands for a regulator controller that drives two rails, a core rail and a northbridge rail. A single host writes to it over an open-drain clock and data pair that uses fast-mode I2C/SMBus signalling. The only transaction it accepts is a Send Byte write: a 7-bit address, a write bit, and one data byte that carries a 7-bit VID code. The address decides which rail, or both, takes the new code. The block never returns data. It drives the data line low only to acknowledge.

When the regulator enable rises, the block treats the two bus lines as a 2-bit boot code. It looks that code up in a parameter table, loads the VID of both rails from the table, and turns both rails on. Bus commands have no effect until the power-good input is high. Each rail has a 7-bit target VID output and a one-cycle update strobe. A strobe is a valid pulse without a ready: the rail logic downstream must take the new code in the cycle the strobe is high, and no back-pressure is possible. A VID code counts down in voltage: 0 is the highest output and each step lowers it by 12.5 mV.

Top module: `svid_rx`

## Requirements
- R1: A start is the data line falling while the clock line is high. The next eight rising clock edges sample the address MSB first, with the write bit (0) last. On a matching write address, the block pulls the data line low for the ninth clock.
- R2: Address 7'b1100011 with the write bit writes the new VID to both rails.
- R3: Address 7'b1100010 writes the core rail only. Address 7'b1100001 writes the northbridge rail only.
- R4: Any other address, or any address with the read bit (1), gets no acknowledge, no data acknowledge and no update.
- R5: The VID is bits 6:0 of the data byte. Bit 7 is ignored.
- R6: The block always acknowledges the data byte of an accepted address. The VID register changes only after that acknowledge clock falls, and it changes together with a single-cycle update strobe for each target rail.
- R7: A stop, or a repeated start, before the data acknowledge ends the command with no update. A repeated start also begins a new command.
- R8: On the rising edge of enable, the block reads boot code {clock line, data line} and loads both VIDs from the table. The default table is code 0 to 7'h20, 1 to 7'h28, 2 to 7'h30 and 3 to 7'h38. It also turns both rail enables on and pulses both strobes.
- R9: While power-good is low, the block ignores bus traffic: no acknowledge and no update.
- R10: The data line is pulled low only during acknowledge bit times. The pull starts after a clock fall and is released after the clock fall that ends the acknowledge.
- R11: Reset sets both VIDs to 7'h7F with the rails and strobes off. While enable is low, both rail enables are low and no strobe occurs.
- R12: A pulse on either line shorter than the filter length (four system clocks by default) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable; rising edge loads the boot VID |
| pgood | input | 1 | Power-good; bus commands accepted only while high |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | Pulls the data line low when high (acknowledge) |
| core_vid | output | 7 | Core rail target VID |
| core_upd | output | 1 | Core VID update strobe |
| core_en | output | 1 | Core rail enable |
| nb_vid | output | 7 | Northbridge rail target VID |
| nb_upd | output | 1 | Northbridge VID update strobe |
| nb_en | output | 1 | Northbridge rail enable |

## Verification
The commit of a serial command and the drop of enable can fall in the same system cycle, because the commit waits on the filtered clock fall that ends the data acknowledge. The bench lowers enable at each of ten successive cycle offsets after the bench drives that clock fall, so the drop lands before, on and after the commit. For every offset it requires both rail enables to go low. It also requires the core VID to show either the new code with exactly one strobe or the old code with none, never a mixed result.

// File: rtl/svid_pkg.sv
package svid_pkg;
  localparam int VID_W = 7;
  localparam int NRAIL = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK1, S_DATA, S_ACK2, S_SKIP
  } eng_state_e;

  typedef logic [NRAIL-1:0] rail_mask_t;  // bit 0 core, bit 1 northbridge
endpackage

// File: rtl/svid_filt.sv
module svid_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter bit IDLE_LVL    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sy;
  logic [CW-1:0]          cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= {SYNC_STAGES{IDLE_LVL}};
    else        sy <= {sy[SYNC_STAGES-2:0], din};
  end

  // output follows the synchronized level only after FILT_LEN equal samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= IDLE_LVL;
      cnt  <= '0;
    end else if (sy[SYNC_STAGES-1] == dout) begin
      cnt <= '0;
    end else if (cnt == CW'(FILT_LEN - 1)) begin
      dout <= sy[SYNC_STAGES-1];
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/svid_bus.sv
module svid_bus #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_f,
  output logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic [1:0] raw, filt;
  logic       scl_p, sda_p;

  assign raw = {sda_in, scl_in};

  for (genvar i = 0; i < 2; i++) begin : g_line
    svid_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .IDLE_LVL(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_n), .din(raw[i]), .dout(filt[i])
    );
  end

  assign scl_f = filt[0];
  assign sda_f = filt[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_c  = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_c   = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/svid_eng.sv
module svid_eng
  import svid_pkg::*;
#(
  parameter logic [6:0] ADDR_BOTH = 7'b1100011,
  parameter logic [6:0] ADDR_CORE = 7'b1100010,
  parameter logic [6:0] ADDR_NB   = 7'b1100001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             sda_f,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_c,
  input  logic             stop_c,
  output logic             sda_pull,
  output logic             cmt,
  output rail_mask_t       cmt_mask,
  output logic [VID_W-1:0] cmt_vid
);
  eng_state_e st;
  logic [7:0] sh;
  logic [3:0] cnt;
  rail_mask_t hit;

  // address byte decode: sh[7:1] address, sh[0] read/write
  always_comb begin
    hit = '0;
    if (!sh[0]) begin
      if (sh[7:1] == ADDR_BOTH)      hit = 2'b11;
      else if (sh[7:1] == ADDR_CORE) hit = 2'b01;
      else if (sh[7:1] == ADDR_NB)   hit = 2'b10;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= '0;
      cnt      <= '0;
      sda_pull <= 1'b0;
      cmt      <= 1'b0;
      cmt_mask <= '0;
      cmt_vid  <= '0;
    end else if (!active) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sda_pull <= 1'b0;
      cmt      <= 1'b0;
    end else begin
      cmt <= 1'b0;
      if (start_c) begin
        st       <= S_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        st       <= S_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (st)
          S_ADDR, S_DATA: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == S_DATA) begin
                cmt_vid  <= sh[VID_W-1:0];
                sda_pull <= 1'b1;
                st       <= S_ACK2;
              end else if (hit != '0) begin
                cmt_mask <= hit;
                sda_pull <= 1'b1;
                st       <= S_ACK1;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_ACK1: if (scl_fall) begin
            sda_pull <= 1'b0;
            cnt      <= '0;
            st       <= S_DATA;
          end
          S_ACK2: if (scl_fall) begin
            sda_pull <= 1'b0;
            cmt      <= 1'b1;
            st       <= S_SKIP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/svid_regs.sv
module svid_regs
  import svid_pkg::*;
#(
  parameter logic [4*VID_W-1:0] BOOT_VIDS = {7'h38, 7'h30, 7'h28, 7'h20},
  parameter logic [VID_W-1:0]   RST_VID   = 7'h7F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       boot_code,
  input  logic             cmt,
  input  rail_mask_t       cmt_mask,
  input  logic [VID_W-1:0] cmt_vid,
  output logic [VID_W-1:0] vid [NRAIL],
  output logic [NRAIL-1:0] upd,
  output logic [NRAIL-1:0] rail_en
);
  logic             en_q;
  logic             boot_ld;
  logic [VID_W-1:0] boot_vid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  assign boot_ld  = en & ~en_q;
  assign boot_vid = BOOT_VIDS[boot_code*VID_W +: VID_W];

  for (genvar r = 0; r < NRAIL; r++) begin : g_rail
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vid[r]     <= RST_VID;
        upd[r]     <= 1'b0;
        rail_en[r] <= 1'b0;
      end else if (!en) begin
        upd[r]     <= 1'b0;
        rail_en[r] <= 1'b0;
      end else if (boot_ld) begin
        vid[r]     <= boot_vid;
        upd[r]     <= 1'b1;
        rail_en[r] <= 1'b1;
      end else if (cmt && cmt_mask[r]) begin
        vid[r] <= cmt_vid;
        upd[r] <= 1'b1;
      end else begin
        upd[r] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/svid_rx.sv
module svid_rx
  import svid_pkg::*;
#(
  parameter int                 SYNC_STAGES = 2,
  parameter int                 FILT_LEN    = 4,
  parameter logic [6:0]         ADDR_BOTH   = 7'b1100011,
  parameter logic [6:0]         ADDR_CORE   = 7'b1100010,
  parameter logic [6:0]         ADDR_NB     = 7'b1100001,
  parameter logic [4*VID_W-1:0] BOOT_VIDS   = {7'h38, 7'h30, 7'h28, 7'h20},
  parameter logic [VID_W-1:0]   RST_VID     = 7'h7F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pgood,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull,
  output logic [VID_W-1:0] core_vid,
  output logic             core_upd,
  output logic             core_en,
  output logic [VID_W-1:0] nb_vid,
  output logic             nb_upd,
  output logic             nb_en
);
  logic             scl_f, sda_f, scl_rise, scl_fall, start_c, stop_c;
  logic             cmt;
  rail_mask_t       cmt_mask;
  logic [VID_W-1:0] cmt_vid;
  logic [VID_W-1:0] vid [NRAIL];
  logic [NRAIL-1:0] upd, rail_en;

  svid_bus #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_bus (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_f(scl_f), .sda_f(sda_f), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  svid_eng #(.ADDR_BOTH(ADDR_BOTH), .ADDR_CORE(ADDR_CORE), .ADDR_NB(ADDR_NB)) u_eng (
    .clk(clk), .rst_n(rst_n), .active(en & pgood), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c),
    .sda_pull(sda_pull), .cmt(cmt), .cmt_mask(cmt_mask), .cmt_vid(cmt_vid)
  );

  svid_regs #(.BOOT_VIDS(BOOT_VIDS), .RST_VID(RST_VID)) u_regs (
    .clk(clk), .rst_n(rst_n), .en(en), .boot_code({scl_f, sda_f}),
    .cmt(cmt), .cmt_mask(cmt_mask), .cmt_vid(cmt_vid),
    .vid(vid), .upd(upd), .rail_en(rail_en)
  );

  assign core_vid = vid[0];
  assign nb_vid   = vid[1];
  assign core_upd = upd[0];
  assign nb_upd   = upd[1];
  assign core_en  = rail_en[0];
  assign nb_en    = rail_en[1];
endmodule

// File: rtl/svid_rx_chk.sv
module svid_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       pgood,
  input logic       scl_f,
  input logic       sda_pull,
  input logic [6:0] core_vid,
  input logic       core_upd,
  input logic       core_en,
  input logic [6:0] nb_vid,
  input logic       nb_upd,
  input logic       nb_en
);
  // R10: pull starts only while the filtered clock is low
  p_pull_on_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(!scl_f));

  // R10: a release while the engine stays active happens with the clock low
  p_pull_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_pull) && $past(en) && $past(pgood)) |-> $past(!scl_f));

  // R6: a VID moves only together with its strobe
  p_core_vid_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_vid) |-> core_upd);
  p_nb_vid_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nb_vid) |-> nb_upd);

  // R9: no acknowledge while power-good is low
  p_no_ack_pg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pgood |=> !sda_pull);

  // R11: enable low turns the rails and strobes off
  p_rails_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!core_en && !nb_en && !core_upd && !nb_upd));

  // R8: turning the rails on always comes with a boot load on both
  p_boot_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_en) |-> (core_upd && nb_upd && nb_en));
endmodule

bind svid_rx svid_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pgood(pgood), .scl_f(scl_f),
  .sda_pull(sda_pull), .core_vid(core_vid), .core_upd(core_upd), .core_en(core_en),
  .nb_vid(nb_vid), .nb_upd(nb_upd), .nb_en(nb_en)
);

// File: tb/sim_svid_rx.sv
`timescale 1ns/1ps
module sim_svid_rx;
  localparam int H = 20;  // bus half-phase in system clocks

  logic       clk = 1'b0;
  logic       rst_n, en, pgood, scl_m, sda_m;
  logic       sda_pull, core_upd, core_en, nb_upd, nb_en;
  logic [6:0] core_vid, nb_vid;
  logic       sda_line;

  int n_chk = 0, n_fail = 0;
  int cu = 0, nu = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  svid_rx u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .pgood(pgood), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .core_vid(core_vid), .core_upd(core_upd), .core_en(core_en),
    .nb_vid(nb_vid), .nb_upd(nb_upd), .nb_en(nb_en)
  );

  always @(posedge clk) begin
    cu <= cu + int'(core_upd);
    nu <= nu + int'(nb_upd);
  end

  // {addr[6:0], rw, data[7:0], ack, core_hit, nb_hit}
  localparam logic [18:0] VEC [8] = '{
    {7'b1100011, 1'b0, 8'h00, 3'b111},
    {7'b1100010, 1'b0, 8'h15, 3'b110},
    {7'b1100001, 1'b0, 8'h7F, 3'b101},
    {7'b1100011, 1'b0, 8'h8A, 3'b111},
    {7'b1100000, 1'b0, 8'h11, 3'b000},
    {7'b1100010, 1'b1, 8'h22, 3'b000},
    {7'b0100011, 1'b0, 8'h33, 3'b000},
    {7'b1100001, 1'b0, 8'h44, 3'b101}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic wbit(input bit b, input bit gl);
    sda_m = b;
    if (gl) begin
      wt(H/2); scl_m = 1'b1; wt(2); scl_m = 1'b0; wt(H/2 - 2);
    end else wt(H);
    scl_m = 1'b1;
    wt(H/2);
    check(sda_line == b, "R10 line free in data bit", int'(sda_line), int'(b));
    if (gl && b) begin
      sda_m = 1'b0; wt(2); sda_m = 1'b1; wt(H/2 - 2);
    end else wt(H/2);
    scl_m = 1'b0;
    wt(H);
  endtask

  task automatic wbyte(input logic [7:0] v, input bit gl);
    for (int i = 7; i >= 0; i--) wbit(v[i], gl);
  endtask

  task automatic ackbit(output bit a);
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H/2);
    a = !sda_line;
    wt(H/2);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic xfer(input logic [6:0] ad, input bit rw, input logic [7:0] d, input bit gl,
                      output bit a1, output bit a2);
    bus_start();
    wbyte({ad, rw}, 1'b0);
    ackbit(a1);
    wbyte(d, gl);
    ackbit(a2);
    bus_stop();
    wt(H);
  endtask

  initial begin
    wt(150000);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    bit a1, a2;
    int c0, n0;
    logic [6:0] mc, mn, old;

    rst_n = 1'b0; en = 1'b0; pgood = 1'b0; scl_m = 1'b1; sda_m = 1'b0;
    wt(5);
    // R11 reset state
    check(core_vid == 7'h7F, "R11 reset core vid", core_vid, 'h7F);
    check(nb_vid == 7'h7F, "R11 reset nb vid", nb_vid, 'h7F);
    check(!core_en && !nb_en, "R11 reset rails off", {core_en, nb_en}, 0);
    check(!sda_pull, "R11 reset no pull", sda_pull, 0);
    rst_n = 1'b1;
    wt(20);

    // R8 boot code {clock=1, data=0} = 2 -> 7'h30
    c0 = cu; n0 = nu;
    en = 1'b1;
    wt(10);
    check(core_vid == 7'h30, "R8 boot core vid", core_vid, 'h30);
    check(nb_vid == 7'h30, "R8 boot nb vid", nb_vid, 'h30);
    check(core_en && nb_en, "R8 rails on", {core_en, nb_en}, 3);
    check(cu - c0 == 1 && nu - n0 == 1, "R8 boot strobes", (cu - c0) + (nu - n0), 2);
    sda_m = 1'b1;
    wt(H);

    // R9 bus ignored before power-good
    c0 = cu;
    xfer(7'b1100011, 1'b0, 8'h05, 1'b0, a1, a2);
    check(!a1, "R9 no ack before power-good", a1, 0);
    check(core_vid == 7'h30 && cu == c0, "R9 no update before power-good", core_vid, 'h30);
    pgood = 1'b1;
    wt(10);
    mc = 7'h30; mn = 7'h30;

    // R1..R6 vector table
    for (int k = 0; k < 8; k++) begin
      logic [18:0] v;
      v = VEC[k];
      c0 = cu; n0 = nu;
      xfer(v[18:12], v[11], v[10:3], 1'b0, a1, a2);
      if (v[1]) mc = v[9:3];
      if (v[0]) mn = v[9:3];
      check(a1 == v[2], "R1/R4 address ack", a1, v[2]);
      check(a2 == v[2], "R6/R4 data ack", a2, v[2]);
      check(core_vid == mc, "R2/R3/R5 core vid", core_vid, mc);
      check(nb_vid == mn, "R2/R3/R5 nb vid", nb_vid, mn);
      check(cu - c0 == int'(v[1]), "R6 core strobe count", cu - c0, v[1]);
      check(nu - n0 == int'(v[0]), "R6 nb strobe count", nu - n0, v[0]);
    end

    // R7 stop in the middle of the data byte
    c0 = cu;
    bus_start();
    wbyte({7'b1100010, 1'b0}, 1'b0);
    ackbit(a1);
    for (int i = 0; i < 4; i++) wbit(1'b1, 1'b0);
    bus_stop();
    wt(H);
    check(a1 && core_vid == mc && cu == c0, "R7 stop aborts", core_vid, mc);

    // R7 repeated start aborts and opens a new command
    c0 = cu;
    bus_start();
    wbyte({7'b1100010, 1'b0}, 1'b0);
    ackbit(a1);
    for (int i = 0; i < 4; i++) wbit(1'b0, 1'b0);
    bus_start();
    wbyte({7'b1100001, 1'b0}, 1'b0);
    ackbit(a1);
    wbyte(8'h66, 1'b0);
    ackbit(a2);
    bus_stop();
    wt(H);
    check(core_vid == mc && cu == c0, "R7 repeated start aborts", core_vid, mc);
    check(a1 && a2 && nb_vid == 7'h66, "R7 new command after repeated start", nb_vid, 'h66);
    mn = 7'h66;

    // R12 short pulses on both lines during the data byte
    xfer(7'b1100010, 1'b0, 8'h2A, 1'b1, a1, a2);
    check(a2 && core_vid == 7'h2A, "R12 glitches filtered", core_vid, 'h2A);

    // enable drop swept across the commit of the data acknowledge
    for (int off = 0; off < 10; off++) begin
      old = core_vid;
      c0 = cu;
      bus_start();
      wbyte({7'b1100010, 1'b0}, 1'b0);
      ackbit(a1);
      wbyte(8'h11, 1'b0);
      sda_m = 1'b1; wt(H);
      scl_m = 1'b1; wt(H);
      scl_m = 1'b0;
      wt(off);
      en = 1'b0;
      wt(30);
      check(!core_en && !nb_en, "R11 rails off after enable drop", {core_en, nb_en}, 0);
      check((core_vid == 7'h11 && cu - c0 == 1) || (core_vid == old && cu == c0),
            "R6/R11 commit vs enable drop", core_vid, 'h11);
      bus_stop();
      wt(H);
      en = 1'b1;
      wt(10);
      // R8 idle lines give boot code 3 -> 7'h38
      check(core_vid == 7'h38, "R8 boot code 3", core_vid, 'h38);
    end

    en = 1'b0;
    wt(10);
    check(!core_en && !nb_en, "R11 final disable", {core_en, nb_en}, 0);
    report();
  end
endmodule